// File: doc/BRIEF.md
# Two-Channel GPIO Register Block

A memory-mapped general-purpose I/O controller with two pin channels. Each channel holds an output latch and a direction register and drives the pads through output-data and output-enable signals. Pins set as inputs are brought in through a synchroniser and read back through the channel's data word. Each channel's width, reset values and input synchroniser depth are parameters. The second channel exists only when the dual-channel parameter is set.

A change on any input-direction pin of a channel sets that channel's interrupt status bit. A per-channel enable mask and a global gate combine the status bits into one interrupt line. Status bits are cleared by writing ones to them. Software reaches the block through a single-cycle port: read data is returned combinationally in the same cycle as the address, and writes take effect at the next clock edge.

Top module: `gpio2ch_regs`

## Requirements
- R1: Byte offsets of the channel registers: channel 0 data at 0x000 and direction at 0x004; channel 1 data at 0x008 and direction at 0x00C. `rdata_o` reflects `addr_i` in the same cycle. A write with `we_i` high updates the register at the next rising clock edge.
- R2: A direction bit of 1 makes the pin an input and a 0 makes it an output. `gpioN_oe_o` is the bitwise inverse of the direction register, and `gpioN_o` is the output latch.
- R3: Reset values:
  - the output latch is loaded from `CHn_DOUT_RST` (default zero);
  - the direction register is loaded from `CHn_DIR_RST` (default all ones, so every pin is an input);
  - status, enable and global-enable are zero.
- R4: Bits at or above a channel's width read as zero and ignore writes. With `DUAL` = 0, channel 1 reads as zero, its change detect is off and its pad outputs are low.
- R5: A data read returns, for each input bit, the pad value after a `SYNC_STAGES`-flop synchroniser, and for each output bit the output latch. With the default of 2, a pad change is visible after the second rising edge.
- R6: A channel's status bit sets one edge after its synchronised input differs from the previous cycle's value on an input-direction bit. This is the third edge after a pad change with 2 sync stages. Changes on output-direction pins never set status.
- R7: The status register is at 0x120, with bit 0 for channel 0 and bit 1 for channel 1. Writing 1 to a bit clears it and writing 0 leaves it unchanged. When a set and a clear reach the same bit in one cycle, the set wins.
- R8: The enable register at 0x128 uses bits [1:0], placed as in the status register. The global enable is bit 31 of 0x11C, and its other bits read as zero. `irq_o` = global enable AND OR over channels of (status AND enable).
- R9: Any offset other than the seven listed reads as zero and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 9 | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| gpio0_i | input | CH0_W | Channel 0 pad inputs |
| gpio0_o | output | CH0_W | Channel 0 output latch |
| gpio0_oe_o | output | CH0_W | Channel 0 output enables |
| gpio1_i | input | CH1_W | Channel 1 pad inputs |
| gpio1_o | output | CH1_W | Channel 1 output latch |
| gpio1_oe_o | output | CH1_W | Channel 1 output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that the pad inputs may change in any cycle, with no relation to the clock. They also assume that `we_i` is a one-cycle strobe that may land in the same cycle as an input change, which is why the set-over-clear ordering is checked.

The stimulus changes pads and issues writes only between clock edges. It lines up one status clear with the exact edge at which a channel change lands, so that the set and the clear meet on the same edge. A pseudo-random phase then mixes pad toggles with writes to every defined offset and to undefined ones, so the global-gate and output-pin properties are exercised in many register states.

// File: rtl/gpio2ch_pkg.sv
package gpio2ch_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam logic [ADDR_W-1:0] OFS_DATA0 = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_DIR0  = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_DATA1 = 9'h008;
  localparam logic [ADDR_W-1:0] OFS_DIR1  = 9'h00C;
  localparam logic [ADDR_W-1:0] OFS_GIE   = 9'h11C;
  localparam logic [ADDR_W-1:0] OFS_STS   = 9'h120;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 9'h128;
  localparam int unsigned GIE_BIT = 31;
  localparam int unsigned NCH     = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_channel.sv
module gpio_channel #(
  parameter int unsigned W           = 32,
  parameter logic [31:0] DOUT_RST    = 32'h0,
  parameter logic [31:0] DIR_RST     = 32'hFFFF_FFFF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         data_we_i,
  input  logic         dir_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] oe_o,
  output logic [31:0]  data_rd_o,
  output logic [31:0]  dir_rd_o,
  output logic         change_o
);
  logic [W-1:0] dout_q, dir_q, in_sync, in_prev;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (in_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= DOUT_RST[W-1:0];
      dir_q   <= DIR_RST[W-1:0];
      in_prev <= '0;
    end else begin
      in_prev <= in_sync;
      if (data_we_i) dout_q <= wdata_i;
      if (dir_we_i)  dir_q  <= wdata_i;
    end
  end

  // only input-direction bits may flag a change
  assign change_o  = |((in_sync ^ in_prev) & dir_q);
  assign data_rd_o = 32'((in_sync & dir_q) | (dout_q & ~dir_q));
  assign dir_rd_o  = 32'(dir_q);
  assign pad_o     = dout_q;
  assign oe_o      = ~dir_q;

  // R2
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> (oe_o == ~$past(wdata_i)));

  // R6
  out_pins_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == '0) |-> !change_o);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic           en_we_i,
  input  logic [NCH-1:0] en_wdata_i,
  input  logic           gie_we_i,
  input  logic           gie_wdata_i,
  output logic [NCH-1:0] sts_o,
  output logic [NCH-1:0] en_o,
  output logic           gie_o,
  output logic           irq_o
);
  logic [NCH-1:0] sts_q, en_q;
  logic           gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_i) | set_i;  // set beats clear
      if (en_we_i)  en_q  <= en_wdata_i;
      if (gie_we_i) gie_q <= gie_wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign gie_o = gie_q;
  assign irq_o = gie_q & |(sts_q & en_q);

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_i |=> ((sts_q & $past(set_i)) == $past(set_i)));

  // R7
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(clr_i & ~set_i) |=> ((sts_q & $past(clr_i & ~set_i)) == '0));

  // R8
  gie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |-> !irq_o);
endmodule

// File: rtl/gpio2ch_regs.sv
module gpio2ch_regs
  import gpio2ch_pkg::*;
#(
  parameter int unsigned CH0_W        = 32,
  parameter int unsigned CH1_W        = 32,
  parameter bit          DUAL         = 1'b1,
  parameter logic [31:0] CH0_DOUT_RST = 32'h0,
  parameter logic [31:0] CH0_DIR_RST  = 32'hFFFF_FFFF,
  parameter logic [31:0] CH1_DOUT_RST = 32'h0,
  parameter logic [31:0] CH1_DIR_RST  = 32'hFFFF_FFFF,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [CH0_W-1:0]  gpio0_i,
  output logic [CH0_W-1:0]  gpio0_o,
  output logic [CH0_W-1:0]  gpio0_oe_o,
  input  logic [CH1_W-1:0]  gpio1_i,
  output logic [CH1_W-1:0]  gpio1_o,
  output logic [CH1_W-1:0]  gpio1_oe_o,
  output logic              irq_o
);
  localparam logic [NCH-1:0] CH_MASK = DUAL ? 2'b11 : 2'b01;

  logic [31:0]    data0_rd, dir0_rd, data1_rd, dir1_rd;
  logic [NCH-1:0] chg, sts, ien, clr;
  logic           gie;

  gpio_channel #(
    .W(CH0_W), .DOUT_RST(CH0_DOUT_RST), .DIR_RST(CH0_DIR_RST), .SYNC_STAGES(SYNC_STAGES)
  ) u_ch0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_we_i(we_i && addr_i == OFS_DATA0),
    .dir_we_i (we_i && addr_i == OFS_DIR0),
    .wdata_i  (wdata_i[CH0_W-1:0]),
    .pad_i    (gpio0_i),
    .pad_o    (gpio0_o),
    .oe_o     (gpio0_oe_o),
    .data_rd_o(data0_rd),
    .dir_rd_o (dir0_rd),
    .change_o (chg[0])
  );

  if (DUAL) begin : g_ch1
    gpio_channel #(
      .W(CH1_W), .DOUT_RST(CH1_DOUT_RST), .DIR_RST(CH1_DIR_RST), .SYNC_STAGES(SYNC_STAGES)
    ) u_ch1 (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .data_we_i(we_i && addr_i == OFS_DATA1),
      .dir_we_i (we_i && addr_i == OFS_DIR1),
      .wdata_i  (wdata_i[CH1_W-1:0]),
      .pad_i    (gpio1_i),
      .pad_o    (gpio1_o),
      .oe_o     (gpio1_oe_o),
      .data_rd_o(data1_rd),
      .dir_rd_o (dir1_rd),
      .change_o (chg[1])
    );
  end else begin : g_no_ch1
    assign gpio1_o    = '0;
    assign gpio1_oe_o = '0;
    assign data1_rd   = '0;
    assign dir1_rd    = '0;
    assign chg[1]     = 1'b0;
  end

  assign clr = (we_i && addr_i == OFS_STS) ? (wdata_i[NCH-1:0] & CH_MASK) : '0;

  gpio_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (chg),
    .clr_i      (clr),
    .en_we_i    (we_i && addr_i == OFS_IEN),
    .en_wdata_i (wdata_i[NCH-1:0] & CH_MASK),
    .gie_we_i   (we_i && addr_i == OFS_GIE),
    .gie_wdata_i(wdata_i[GIE_BIT]),
    .sts_o      (sts),
    .en_o       (ien),
    .gie_o      (gie),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_DATA0: rdata_o = data0_rd;
      OFS_DIR0:  rdata_o = dir0_rd;
      OFS_DATA1: rdata_o = data1_rd;
      OFS_DIR1:  rdata_o = dir1_rd;
      OFS_GIE:   rdata_o[GIE_BIT] = gie;
      OFS_STS:   rdata_o[NCH-1:0] = sts;
      OFS_IEN:   rdata_o[NCH-1:0] = ien;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: tb/gpio2ch_regs_tb.sv
`timescale 1ns/1ps
module gpio2ch_regs_tb;
  localparam int W0 = 8;
  localparam int W1 = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [W0-1:0] p0 = '0, g0, oe0;
  logic [W1-1:0] p1 = '0, g1, oe1;
  logic        irq;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio2ch_regs #(
    .CH0_W(W0), .CH1_W(W1), .DUAL(1'b1),
    .CH1_DOUT_RST(32'h0000_0A5C), .CH1_DIR_RST(32'hFFFF_F0FF)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .gpio0_i(p0), .gpio0_o(g0), .gpio0_oe_o(oe0),
    .gpio1_i(p1), .gpio1_o(g1), .gpio1_oe_o(oe1), .irq_o(irq)
  );

  // behavioural reference state
  logic [31:0] m_dout[2], m_dir[2], m_sa[2], m_sb[2], m_prev[2];
  logic [1:0]  m_sts, m_en;
  logic        m_gie;
  int          wid[2] = '{W0, W1};

  function automatic logic [31:0] wmask(int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  function automatic logic [31:0] padv(int c);
    return (c == 0) ? 32'(p0) : 32'(p1);
  endfunction

  function automatic logic [31:0] m_read(logic [8:0] a);
    case (a)
      9'h000: return (m_sb[0] & m_dir[0]) | (m_dout[0] & ~m_dir[0]);
      9'h004: return m_dir[0];
      9'h008: return (m_sb[1] & m_dir[1]) | (m_dout[1] & ~m_dir[1]);
      9'h00C: return m_dir[1];
      9'h11C: return {m_gie, 31'h0};
      9'h120: return {30'h0, m_sts};
      9'h128: return {30'h0, m_en};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [8:0] a);
    case (a)
      9'h000, 9'h008: return "R5";
      9'h004, 9'h00C: return "R1";
      9'h11C, 9'h128: return "R8";
      9'h120:         return "R7";
      default:        return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_dout[0] = 32'h0;          m_dir[0] = wmask(W0);
    m_dout[1] = 32'h0000_0A5C;  m_dir[1] = 32'hFFFF_F0FF & wmask(W1);
    for (int c = 0; c < 2; c++) begin m_sa[c] = 0; m_sb[c] = 0; m_prev[c] = 0; end
    m_sts = 0; m_en = 0; m_gie = 0;
  endtask

  task automatic model_step();
    logic [1:0] setv, clrv;
    for (int c = 0; c < 2; c++) setv[c] = |((m_sb[c] ^ m_prev[c]) & m_dir[c]);
    clrv  = (we && addr == 9'h120) ? wdata[1:0] : 2'b00;
    m_sts = (m_sts & ~clrv) | setv;
    if (we && addr == 9'h128) m_en  = wdata[1:0];
    if (we && addr == 9'h11C) m_gie = wdata[31];
    for (int c = 0; c < 2; c++) begin
      m_prev[c] = m_sb[c];
      m_sb[c]   = m_sa[c];
      m_sa[c]   = padv(c) & wmask(wid[c]);
      if (we && addr == 9'(c * 8))     m_dout[c] = wdata & wmask(wid[c]);
      if (we && addr == 9'(c * 8 + 4)) m_dir[c]  = wdata & wmask(wid[c]);
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // compare every output to the model, then advance one clock
  task automatic cyc();
    #1;
    chk(tag_of(addr), rdata, m_read(addr));
    chk("R2", 32'(g0), m_dout[0]);
    chk("R2", 32'(oe0), ~m_dir[0] & wmask(W0));
    chk("R2", 32'(g1), m_dout[1]);
    chk("R2", 32'(oe1), ~m_dir[1] & wmask(W1));
    chk("R8", 32'(irq), 32'(m_gie & |(m_sts & m_en)));
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    addr = a; we = 1'b1; wdata = d;
    cyc();
    we = 1'b0; wdata = '0;
  endtask

  task automatic exp_rd(string req, logic [8:0] a, logic [31:0] e);
    addr = a; we = 1'b0;
    #1 chk(req, rdata, e);
    cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    model_reset();

    // R3 reset state
    exp_rd("R3", 9'h004, 32'h0000_00FF);
    exp_rd("R3", 9'h00C, 32'h0000_00FF);
    exp_rd("R3", 9'h008, 32'h0000_0A00);
    #1 chk("R3", 32'(g1), 32'h0000_0A5C);
    chk("R3", 32'(oe1), 32'h0000_0F00);
    chk("R3", 32'(irq), 32'h0);
    exp_rd("R3", 9'h120, 32'h0);
    exp_rd("R3", 9'h11C, 32'h0);

    // R1 R2 direction and data
    wr(9'h004, 32'h0000_00F0);
    wr(9'h000, 32'h0000_00A5);
    #1 chk("R2", 32'(oe0), 32'h0000_000F);
    chk("R2", 32'(g0), 32'h0000_00A5);
    exp_rd("R5", 9'h000, 32'h0000_0005);

    // R4 bits above width
    wr(9'h000, 32'hFFFF_FFFF);
    exp_rd("R4", 9'h000, 32'h0000_000F);
    wr(9'h004, 32'hFFFF_FFF0);
    exp_rd("R4", 9'h004, 32'h0000_00F0);
    wr(9'h00C, 32'hFFFF_FFFF);
    exp_rd("R4", 9'h00C, 32'h0000_0FFF);

    // R5 two-stage sync latency, R6 status on third edge
    p0 = 8'h30;
    exp_rd("R5", 9'h000, 32'h0000_000F);
    exp_rd("R5", 9'h000, 32'h0000_000F);
    exp_rd("R5", 9'h000, 32'h0000_003F);
    exp_rd("R6", 9'h120, 32'h0000_0001);

    // R6 output pin change ignored
    wr(9'h120, 32'h1);
    exp_rd("R6", 9'h120, 32'h0);
    p0 = 8'h31;
    idle(4);
    exp_rd("R6", 9'h120, 32'h0);

    // R8 enables and global gate
    wr(9'h128, 32'h3);
    wr(9'h11C, 32'h8000_0000);
    #1 chk("R8", 32'(irq), 32'h0);
    p0 = 8'h21;
    idle(3);
    #1 chk("R8", 32'(irq), 32'h1);
    wr(9'h11C, 32'h7FFF_FFFF);
    #1 chk("R8", 32'(irq), 32'h0);
    exp_rd("R8", 9'h11C, 32'h0);
    wr(9'h11C, 32'h8000_0000);
    #1 chk("R8", 32'(irq), 32'h1);

    // R7 write-one-to-clear and set-over-clear
    wr(9'h120, 32'h2);
    exp_rd("R7", 9'h120, 32'h1);
    wr(9'h120, 32'h1);
    exp_rd("R7", 9'h120, 32'h0);
    p1 = 12'h001;
    idle(2);
    wr(9'h120, 32'h2);
    exp_rd("R7", 9'h120, 32'h2);
    wr(9'h120, 32'h2);
    exp_rd("R7", 9'h120, 32'h0);

    // R9 undefined offsets
    wr(9'h010, 32'hFFFF_FFFF);
    wr(9'h124, 32'hFFFF_FFFF);
    exp_rd("R9", 9'h010, 32'h0);
    exp_rd("R9", 9'h124, 32'h0);
    exp_rd("R9", 9'h004, 32'h0000_00F0);
    exp_rd("R9", 9'h128, 32'h3);

    // mixed pseudo-random phase, model compared every cycle
    lf = 32'h1D2C_3B4A;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[3:0] < 4) p0 = lf[15:8];
      if (lf[7:4] < 4) p1 = lf[27:16];
      if (lf[10:8] == 0) begin
        case (lf[14:12])
          3'd0: wr(9'h000, lf);
          3'd1: wr(9'h004, {lf[15:0], lf[31:16]});
          3'd2: wr(9'h008, lf);
          3'd3: wr(9'h00C, ~lf);
          3'd4: wr(9'h120, lf);
          3'd5: wr(9'h128, lf);
          3'd6: wr(9'h11C, lf);
          default: wr(9'h0F0, lf);
        endcase
      end else begin
        addr = {lf[20:19] == 2'b11 ? 2'b10 : 2'b00, lf[18:16], 4'h0} | 9'(lf[23:22] << 2);
        cyc();
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule